// File: doc/BRIEF.md
# Power-Down Wake Sequencer

This block puts a small processor core into a low-power sleep state and brings it back out. Software sets a sleep bit, which drops the oscillator enable and the core clock enable together. Two active-low external interrupt pins can end the sleep. A pin counts as a wake source only when its enable bit is set and it is set up as level-sensitive.

On a qualifying falling edge the oscillator enable comes back at once. The core clock release then follows one of two modes. In the timed mode, a 16-bit start-up counter runs on a free-running reference clock, which stands in for the restarted oscillator. In the pin-held mode, release waits until the waking pin returns high.

When the clock is released, the sleep bit clears itself. In the same cycle a one-cycle wake request for the waking pin goes to the interrupt controller, so the handler runs first. A synchronous reset returns the block to the running state from any state.

Top module: `pwrwake_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, osc_en and core_clk_en are 1, sleep_bit is 0 and wake_irq is 0.
- R2: In the running state, a cycle with sleep_wr=1 and sleep_wdata=1 sets sleep_bit to 1 and drives osc_en and core_clk_en to 0 after that clock edge. A write with sleep_wdata=0 changes none of the outputs.
- R3: Pin i (bit i of irq_pin_n, active low) is a wake source only if irq_en[i]=1 and irq_edge_sel[i]=0. A falling edge on a pin that is disabled or configured for edge (irq_edge_sel[i]=1) leaves osc_en and core_clk_en at 0.
- R4: A qualifying pin that goes low before clock edge E0 sets osc_en to 1 after edge E2, while core_clk_en stays 0. osc_en never leaves 0 earlier than that.
- R5: With wake_timed=1, core_clk_en rises max(N,1) reference cycles after osc_en rises, where N is sut_count.
- R6: In the timed mode, the waking pin returning high before the timeout neither cancels nor shortens the wake sequence.
- R7: With wake_timed=0, core_clk_en stays 0 while the waking pin is low. When the pin goes high before edge F0, core_clk_en becomes 1 after edge F2.
- R8: In the cycle core_clk_en rises from a wake, bit src of wake_irq is 1 for exactly one cycle, where src is the waking pin. Bit 0 maps to pin 0.
- R9: sleep_bit clears to 0 in the same cycle core_clk_en is released.
- R10: If both pins qualify and fall in the same cycle, pin 0 wins. In the pin-held mode only the rise of pin 0 releases the clock, and wake_irq is 2'b01.
- R11: A reset asserted during any wake state returns the block to running, with osc_en=1, core_clk_en=1 and sleep_bit=0.
- R12: N is captured from sut_count when sleep is entered. Later changes to sut_count do not alter that wake's timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset (external or power-on) |
| sleep_wr | input | 1 | Software write strobe for the sleep bit |
| sleep_wdata | input | 1 | Value written to the sleep bit |
| irq_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| irq_en | input | 2 | Per-pin interrupt enable |
| irq_edge_sel | input | 2 | Per-pin trigger type: 1 = edge, 0 = level |
| wake_timed | input | 1 | Wake mode: 1 = timed start-up, 0 = held until pin rises |
| sut_count | input | 16 | Start-up timeout in reference cycles |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| sleep_bit | output | 1 | Current value of the sleep bit |
| wake_irq | output | 2 | One-cycle wake interrupt request per pin |

## Verification
Each pin change takes two synchroniser edges and one sequencer edge to act. The bench changes pins on a falling clock edge and samples after the third rising edge, and it also samples once after the second edge to show nothing moved early. In the timed mode, core_clk_en is sampled one cycle before and exactly at N cycles after osc_en rose. In the pin-held mode it is sampled two and three edges after the pin's rise. The one-cycle wake request is checked in its release cycle and again one cycle later.

// File: rtl/pwrwake_pkg.sv
package pwrwake_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_WAIT_TMR = 2'd2,
    ST_WAIT_PIN = 2'd3
  } pw_state_t;

  localparam int unsigned DEF_NUM_IRQ = 2;
  localparam int unsigned DEF_TMR_W   = 16;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[DEPTH-2:0], pin_n[g]};
    end
    // sr[STAGES-1] is the synchronised level, sr[STAGES] its previous value
    assign fall[g] = sr[STAGES]   & ~sr[STAGES-1];
    assign rise[g] = ~sr[STAGES]  &  sr[STAGES-1];
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int unsigned N     = 2,
  parameter int unsigned SRC_W = 1
) (
  input  logic [N-1:0]     fall,
  input  logic [N-1:0]     en,
  input  logic [N-1:0]     edge_sel,
  output logic             hit,
  output logic [SRC_W-1:0] src
);
  logic [N-1:0] qual;
  assign qual = fall & en & ~edge_sel;
  assign hit  = |qual;

  // lowest index has priority: scan from the top down
  always_comb begin
    src = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual[i]) src = SRC_W'(i);
    end
  end
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  // done when one or zero cycles remain; a zero load behaves as one
  assign done = (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (run && !done)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/pwrwake_ctrl.sv
module pwrwake_ctrl
  import pwrwake_pkg::*;
#(
  parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
  parameter int unsigned TMR_W   = DEF_TMR_W,
  parameter int unsigned SYNC    = DEF_SYNC
) (
  input  logic               clk_ref,
  input  logic               rst,
  input  logic               sleep_wr,
  input  logic               sleep_wdata,
  input  logic [NUM_IRQ-1:0] irq_pin_n,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_edge_sel,
  input  logic               wake_timed,
  input  logic [TMR_W-1:0]   sut_count,
  output logic               osc_en,
  output logic               core_clk_en,
  output logic               sleep_bit,
  output logic [NUM_IRQ-1:0] wake_irq
);
  localparam int unsigned SRC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  pw_state_t          state;
  logic [SRC_W-1:0]   src_q;
  logic [NUM_IRQ-1:0] pin_fall, pin_rise;
  logic               wake_hit;
  logic [SRC_W-1:0]   wake_src;
  logic               tmr_done;
  logic               enter_sleep;
  logic               release_now;
  logic [NUM_IRQ-1:0] src_onehot;

  wake_sync #(.N(NUM_IRQ), .STAGES(SYNC)) u_sync (
    .clk   (clk_ref),
    .rst   (rst),
    .pin_n (irq_pin_n),
    .fall  (pin_fall),
    .rise  (pin_rise)
  );

  wake_qual #(.N(NUM_IRQ), .SRC_W(SRC_W)) u_qual (
    .fall     (pin_fall),
    .en       (irq_en),
    .edge_sel (irq_edge_sel),
    .hit      (wake_hit),
    .src      (wake_src)
  );

  assign enter_sleep = (state == ST_RUN) && sleep_wr && sleep_wdata;

  startup_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk_ref),
    .rst      (rst),
    .load     (enter_sleep),
    .load_val (sut_count),
    .run      (state == ST_WAIT_TMR),
    .done     (tmr_done)
  );

  always_comb begin
    release_now = 1'b0;
    case (state)
      ST_WAIT_TMR: release_now = tmr_done;
      ST_WAIT_PIN: release_now = pin_rise[src_q];
      default:     release_now = 1'b0;
    endcase
  end

  assign src_onehot = NUM_IRQ'(1) << src_q;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      state       <= ST_RUN;
      osc_en      <= 1'b1;
      core_clk_en <= 1'b1;
      sleep_bit   <= 1'b0;
      wake_irq    <= '0;
      src_q       <= '0;
    end else begin
      wake_irq <= '0;
      case (state)
        ST_RUN: begin
          if (enter_sleep) begin
            state       <= ST_SLEEP;
            osc_en      <= 1'b0;
            core_clk_en <= 1'b0;
            sleep_bit   <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_hit) begin
            src_q  <= wake_src;
            osc_en <= 1'b1;
            state  <= wake_timed ? ST_WAIT_TMR : ST_WAIT_PIN;
          end
        end
        default: begin
          if (release_now) begin
            state       <= ST_RUN;
            core_clk_en <= 1'b1;
            sleep_bit   <= 1'b0;
            wake_irq    <= src_onehot;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pwrwake_ctrl_chk.sv
module pwrwake_ctrl_chk #(
  parameter int unsigned NUM_IRQ = 2
) (
  input logic               clk_ref,
  input logic               rst,
  input logic               osc_en,
  input logic               core_clk_en,
  input logic               sleep_bit,
  input logic [NUM_IRQ-1:0] wake_irq
);
  p_reset_run_r11: assert property (@(posedge clk_ref)
    rst |=> (osc_en && core_clk_en && !sleep_bit && (wake_irq == '0)));

  p_clk_needs_osc_r4: assert property (@(posedge clk_ref) disable iff (rst)
    !osc_en |-> !core_clk_en);

  p_osc_drop_r2: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(osc_en) |-> (sleep_bit && !core_clk_en));

  p_wake_onehot_r10: assert property (@(posedge clk_ref) disable iff (rst)
    $onehot0(wake_irq));

  p_irq_at_release_r8: assert property (@(posedge clk_ref) disable iff (rst)
    (|wake_irq) |-> (core_clk_en && !$past(core_clk_en)));

  p_bit_clears_r9: assert property (@(posedge clk_ref) disable iff (rst)
    ($rose(core_clk_en) && !$past(rst)) |-> (!sleep_bit && (|wake_irq)));
endmodule

bind pwrwake_ctrl pwrwake_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_ref     (clk_ref),
  .rst         (rst),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .sleep_bit   (sleep_bit),
  .wake_irq    (wake_irq)
);

// File: tb/pwrwake_ctrl_tb.sv
module pwrwake_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_wr = 1'b0, sleep_wdata = 1'b0;
  logic [1:0]  pin_n = 2'b11, en = 2'b11, esel = 2'b00;
  logic        timed = 1'b1;
  logic [15:0] sut = 16'd5;
  logic        osc_en, clk_en, sbit;
  logic [1:0]  wirq;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  pwrwake_ctrl dut_i (
    .clk_ref(clk), .rst(rst), .sleep_wr(sleep_wr), .sleep_wdata(sleep_wdata),
    .irq_pin_n(pin_n), .irq_en(en), .irq_edge_sel(esel), .wake_timed(timed),
    .sut_count(sut), .osc_en(osc_en), .core_clk_en(clk_en),
    .sleep_bit(sbit), .wake_irq(wirq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_wr = 1'b1; sleep_wdata = 1'b1;
    tick(1);
    sleep_wr = 1'b0; sleep_wdata = 1'b0;
  endtask

  task automatic settle();
    pin_n = 2'b11;
    tick(4);
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1 osc in reset", osc_en, 1);
    chk("R1 clk in reset", clk_en, 1);
    rst = 1'b0;
    tick(1);
    chk("R1 osc", osc_en, 1);
    chk("R1 clk", clk_en, 1);
    chk("R1 sleep_bit", sbit, 0);
    chk("R1 wake_irq", wirq, 0);
  endtask

  task automatic t_write_zero();
    sleep_wr = 1'b1; sleep_wdata = 1'b0;
    tick(1);
    sleep_wr = 1'b0;
    tick(1);
    chk("R2 zero write osc", osc_en, 1);
    chk("R2 zero write clk", clk_en, 1);
    chk("R2 zero write bit", sbit, 0);
  endtask

  task automatic t_timed();
    timed = 1'b1; en = 2'b11; esel = 2'b00; sut = 16'd5;
    go_sleep();
    chk("R2 osc off", osc_en, 0);
    chk("R2 clk off", clk_en, 0);
    chk("R2 bit set", sbit, 1);
    sut = 16'd2;
    pin_n[0] = 1'b0;
    tick(2);
    chk("R4 osc not early", osc_en, 0);
    tick(1);
    chk("R4 osc on", osc_en, 1);
    chk("R4 clk still gated", clk_en, 0);
    pin_n[0] = 1'b1;
    tick(4);
    chk("R6 R12 clk gated before timeout", clk_en, 0);
    tick(1);
    chk("R5 clk released", clk_en, 1);
    chk("R8 wake_irq pin0", wirq, 2'b01);
    chk("R9 bit cleared", sbit, 0);
    tick(1);
    chk("R8 wake_irq one cycle", wirq, 2'b00);
    settle();
  endtask

  task automatic t_zero_timeout();
    timed = 1'b1; sut = 16'd0;
    go_sleep();
    pin_n[0] = 1'b0;
    tick(3);
    chk("R5 zero osc", osc_en, 1);
    chk("R5 zero clk gated", clk_en, 0);
    tick(1);
    chk("R5 zero clk after 1", clk_en, 1);
    settle();
  endtask

  task automatic t_untimed();
    timed = 1'b0; en = 2'b11; esel = 2'b00;
    go_sleep();
    pin_n[1] = 1'b0;
    tick(3);
    chk("R4 osc on pin1", osc_en, 1);
    tick(5);
    chk("R7 clk held while low", clk_en, 0);
    pin_n[1] = 1'b1;
    tick(2);
    chk("R7 clk not early", clk_en, 0);
    tick(1);
    chk("R7 clk on rise", clk_en, 1);
    chk("R8 wake_irq pin1", wirq, 2'b10);
    settle();
  endtask

  task automatic t_unqualified();
    timed = 1'b1; sut = 16'd2; en = 2'b10; esel = 2'b00;
    go_sleep();
    pin_n[0] = 1'b0;
    tick(6);
    chk("R3 disabled pin no wake", osc_en, 0);
    pin_n[0] = 1'b1;
    tick(3);
    en = 2'b11; esel = 2'b01;
    pin_n[0] = 1'b0;
    tick(6);
    chk("R3 edge pin no wake", osc_en, 0);
    chk("R3 edge pin clk gated", clk_en, 0);
    pin_n[1] = 1'b0;
    tick(3);
    chk("R3 level pin wakes", osc_en, 1);
    tick(2);
    chk("R3 release", clk_en, 1);
    chk("R8 wake_irq pin1 timed", wirq, 2'b10);
    esel = 2'b00;
    settle();
  endtask

  task automatic t_both();
    timed = 1'b0; en = 2'b11; esel = 2'b00;
    go_sleep();
    pin_n = 2'b00;
    tick(3);
    chk("R10 osc on", osc_en, 1);
    pin_n[1] = 1'b1;
    tick(4);
    chk("R10 pin1 rise ignored", clk_en, 0);
    pin_n[0] = 1'b1;
    tick(3);
    chk("R10 pin0 rise releases", clk_en, 1);
    chk("R10 pin0 wins", wirq, 2'b01);
    settle();
  endtask

  task automatic t_reset_mid();
    timed = 1'b0;
    go_sleep();
    pin_n[0] = 1'b0;
    tick(3);
    chk("R11 in wait osc", osc_en, 1);
    chk("R11 in wait clk", clk_en, 0);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk("R11 osc", osc_en, 1);
    chk("R11 clk", clk_en, 1);
    chk("R11 bit", sbit, 0);
    pin_n[0] = 1'b1;
    tick(4);
    chk("R11 stays running", clk_en, 1);
    chk("R11 no irq", wirq, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !finished) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write_zero();
    t_timed();
    t_zero_timeout();
    t_untimed();
    t_unqualified();
    t_both();
    t_reset_mid();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule